// File: doc/BRIEF.md
# Pipelined Burst Write Driver

This block takes write bursts from a valid/ready command stream and sends them onto a pipelined bus. The bus has two separate phases. The address phase lasts one cycle and carries the burst's address and length code. The data phase follows and sends one word per cycle. A command holds a 32-bit address, a 2-bit length code and up to four 32-bit words. The driver forwards the address of an accepted burst on the next cycle, even while the words of earlier bursts are still going out. So an address phase of a later burst overlaps the data phase of an earlier one.

The words of each accepted burst wait in a small in-order queue until the data phase is free. Data phases never interleave. They run strictly in acceptance order and back to back, with no idle cycle between them. Back-pressure is applied only through `cmd_ready`. It is high whenever the queue has a free slot, and it depends only on the queue occupancy. A command is taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While `cmd_ready` is low, the source must hold its command. A held command has no effect until it is taken. The downstream bus has no back-pressure. A synchronous active-high reset empties the queue and drops both valid strobes.

Top module: `burst_pipe_driver`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `addr_valid` and `data_valid` are low and `cmd_ready` is high.
- R2: A command taken on edge k drives `addr_valid` high for exactly the cycle after edge k, with `addr_out` equal to its address and `addr_burst` equal to its code. On a cycle after an edge where no command was taken, `addr_valid` is low.
- R3: The length code sets the beat count: 2'b00 gives 1 beat, 2'b01 gives 2 beats, 2'b10 gives 4 beats, and 2'b11 is treated as 1 beat.
- R4: Beat i of a burst carries `cmd_data[32*i+31:32*i]`, and beats i = 0,1,2,3 appear on consecutive cycles.
- R5: `data_last` is high only on the final beat of each burst, and never while `data_valid` is low.
- R6: When no beats are pending, the first beat of a burst taken on edge k appears in the cycle after edge k+1, which is one cycle after its address phase.
- R7: Bursts send their data in acceptance order without interleaving. The first beat of a queued burst directly follows the last beat of the previous burst, with no idle cycle.
- R8: `cmd_ready` is low exactly when two bursts are waiting in the queue (not counting the burst whose beats are being driven). A command offered while `cmd_ready` is low is not taken and produces no address phase.
- R9: `data_valid` is low on every cycle where no beat is due.
- R10: Commands keep being taken while beats of earlier bursts are still being driven, so `addr_valid` and `data_valid` can be high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_addr | input | 32 | Burst address |
| cmd_burst | input | 2 | Length code (R3) |
| cmd_data | input | 128 | Words, word i in bits 32*i+31:32*i |
| addr_valid | output | 1 | Address phase strobe |
| addr_out | output | 32 | Address of the burst in its address phase |
| addr_burst | output | 2 | Length code of that burst |
| data_valid | output | 1 | Data beat strobe |
| data_out | output | 32 | Data beat word |
| data_last | output | 1 | Final beat of the burst |

## Verification
A take on edge k is due on the address outputs in the cycle after edge k. On an idle data path, its first beat is due one edge later, and later beats follow on successive edges. When the queue is busy, a burst's first beat is due on the edge after the previous burst's last beat. The bench keeps a behavioural model that it advances on each rising edge from the same inputs. It compares every output against that model at the falling edge, so each result is checked in the cycle it is due. Directed cases also check these latencies explicitly and count the beats of isolated bursts.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  localparam int MAX_BEATS = 4;

  typedef enum logic [1:0] {
    BT_ONE  = 2'b00,
    BT_TWO  = 2'b01,
    BT_FOUR = 2'b10,
    BT_RSVD = 2'b11
  } burst_e;

  // Beat count for a length code; the reserved code behaves as a single beat (R3)
  function automatic int beats_of(logic [1:0] code);
    case (burst_e'(code))
      BT_TWO:  return 2;
      BT_FOUR: return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/bpd_cmd_queue.sv
module bpd_cmd_queue #(
  parameter int WIDTH = 130,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_data = mem[rp];
  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);

  // Push comes from the command handshake at the top level
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // Pop comes from the beat engine
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

endmodule

// File: rtl/bpd_addr_stage.sv
module bpd_addr_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [AW-1:0] in_addr,
  input  logic [1:0]    in_burst,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [1:0]    out_burst
);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= take;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_addr  <= in_addr;
      out_burst <= in_burst;
    end
  end

  assert_addr_follows_take_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(take));

  assert_addr_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !take |=> !out_valid);

endmodule

// File: rtl/bpd_beat_engine.sv
module bpd_beat_engine #(
  parameter int DW = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                q_empty,
  input  logic [2+DW*bpd_pkg::MAX_BEATS-1:0]  q_head,
  output logic                                q_pop,
  output logic                                data_valid,
  output logic [DW-1:0]                       data_word,
  output logic                                data_last
);
  localparam int NB = bpd_pkg::MAX_BEATS;
  localparam int CW = $clog2(NB + 1);
  localparam int IW = $clog2(NB);
  localparam int PW = DW * NB;

  logic [PW-1:0] words_q;
  logic [CW-1:0] nbeats_q;
  logic [CW-1:0] idx_q;
  logic [1:0]    head_code;
  logic [PW-1:0] head_words;
  logic [CW-1:0] head_beats;
  logic          free;
  logic [DW-1:0] word_at [NB];

  assign head_code  = q_head[PW +: 2];
  assign head_words = q_head[PW-1:0];
  assign head_beats = CW'(bpd_pkg::beats_of(head_code));

  // Engine may start a new burst when idle or on the final beat
  assign free  = !data_valid || data_last;
  assign q_pop = free && !q_empty;

  for (genvar g = 0; g < NB; g++) begin : g_slice
    assign word_at[g] = words_q[g*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_valid <= 1'b0;
      data_last  <= 1'b0;
      idx_q      <= '0;
      nbeats_q   <= '0;
    end else if (q_pop) begin
      data_valid <= 1'b1;
      data_last  <= (head_beats == CW'(1));
      idx_q      <= CW'(1);
      nbeats_q   <= head_beats;
    end else if (data_valid && !data_last) begin
      data_last  <= (idx_q == nbeats_q - CW'(1));
      idx_q      <= idx_q + CW'(1);
    end else begin
      data_valid <= 1'b0;
      data_last  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (q_pop) begin
      words_q   <= head_words;
      data_word <= head_words[DW-1:0];
    end else if (data_valid && !data_last) begin
      data_word <= word_at[idx_q[IW-1:0]];
    end
  end

  assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (rst)
    data_last |-> data_valid);

  assert_no_gap_in_burst_R4: assert property (@(posedge clk) disable iff (rst)
    (data_valid && !data_last) |=> data_valid);

  assert_start_from_queue_R6: assert property (@(posedge clk) disable iff (rst)
    (data_valid && !$past(data_valid)) |-> $past(!q_empty));

endmodule

// File: rtl/burst_pipe_driver.sv
module burst_pipe_driver #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int QDEPTH = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cmd_valid,
  output logic                             cmd_ready,
  input  logic [AW-1:0]                    cmd_addr,
  input  logic [1:0]                       cmd_burst,
  input  logic [DW*bpd_pkg::MAX_BEATS-1:0] cmd_data,
  output logic                             addr_valid,
  output logic [AW-1:0]                    addr_out,
  output logic [1:0]                       addr_burst,
  output logic                             data_valid,
  output logic [DW-1:0]                    data_out,
  output logic                             data_last
);
  localparam int EW = 2 + DW * bpd_pkg::MAX_BEATS;

  logic          take;
  logic          q_full, q_empty, q_pop;
  logic [EW-1:0] q_head;

  assign cmd_ready = !q_full;
  assign take      = cmd_valid && cmd_ready;

  bpd_addr_stage #(.AW(AW)) i_addr (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .in_addr   (cmd_addr),
    .in_burst  (cmd_burst),
    .out_valid (addr_valid),
    .out_addr  (addr_out),
    .out_burst (addr_burst)
  );

  bpd_cmd_queue #(.WIDTH(EW), .DEPTH(QDEPTH)) i_queue (
    .clk     (clk),
    .rst     (rst),
    .push    (take),
    .pop     (q_pop),
    .wr_data ({cmd_burst, cmd_data}),
    .rd_data (q_head),
    .full    (q_full),
    .empty   (q_empty)
  );

  bpd_beat_engine #(.DW(DW)) i_beats (
    .clk        (clk),
    .rst        (rst),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .q_pop      (q_pop),
    .data_valid (data_valid),
    .data_word  (data_out),
    .data_last  (data_last)
  );

  // A full queue must have been reached through earlier takes, never straight out of reset
  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cmd_ready);

endmodule

// File: tb/test_burst_pipe_driver.sv
`timescale 1ns/1ps
module test_burst_pipe_driver;
  logic         clk = 1'b0;
  logic         rst;
  logic         cmd_valid;
  logic         cmd_ready;
  logic [31:0]  cmd_addr;
  logic [1:0]   cmd_burst;
  logic [127:0] cmd_data;
  logic         addr_valid;
  logic [31:0]  addr_out;
  logic [1:0]   addr_burst;
  logic         data_valid;
  logic [31:0]  data_out;
  logic         data_last;

  int n_tests = 0;
  int n_fail  = 0;

  burst_pipe_driver i_burst_pipe_driver (.*);

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  logic [127:0] pb_words [$];
  int           pb_n     [$];
  logic [32:0]  cur      [$];
  logic         m_ready = 1'b1, m_acc = 1'b0, m_av = 1'b0, m_dv = 1'b0, m_last = 1'b0;
  logic [31:0]  m_addr, m_data;
  logic [1:0]   m_burst;
  logic [127:0] t_w;
  int           t_n;

  always @(posedge clk) begin
    if (rst) begin
      pb_words.delete(); pb_n.delete(); cur.delete();
      m_acc = 0; m_av = 0; m_dv = 0; m_last = 0;
    end else begin
      m_acc = cmd_valid && (pb_n.size() < 2);
      if (cur.size() == 0 && pb_n.size() > 0) begin
        t_w = pb_words.pop_front();
        t_n = pb_n.pop_front();
        for (int i = 0; i < t_n; i++) cur.push_back({(i == t_n - 1), t_w[i*32 +: 32]});
      end
      if (cur.size() > 0) begin
        {m_last, m_data} = cur.pop_front();
        m_dv = 1;
      end else begin
        m_dv = 0; m_last = 0;
      end
      m_av = m_acc;
      if (m_acc) begin
        m_addr = cmd_addr; m_burst = cmd_burst;
        pb_words.push_back(cmd_data);
        pb_n.push_back(cmd_burst == 2'b01 ? 2 : (cmd_burst == 2'b10 ? 4 : 1));
      end
    end
    m_ready = pb_n.size() < 2;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- per-cycle comparison ----------------
  bit cmp_on = 0;
  int beats_seen = 0;
  bit overlap_seen = 0, stall_seen = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cmd_ready === m_ready, "R8 cmd_ready", cmd_ready, m_ready);
      chk(addr_valid === m_av, "R2 addr_valid", addr_valid, m_av);
      if (m_av) begin
        chk(addr_out === m_addr, "R2 addr_out", addr_out, m_addr);
        chk(addr_burst === m_burst, "R2 addr_burst", addr_burst, m_burst);
      end
      chk(data_valid === m_dv, m_dv ? "R7 data_valid" : "R9 data_valid", data_valid, m_dv);
      if (m_dv) begin
        chk(data_out === m_data, "R4 data_out", data_out, m_data);
        chk(data_last === m_last, "R5 data_last", data_last, m_last);
      end else begin
        chk(data_last === 1'b0, "R5 data_last idle", data_last, 0);
      end
      if (data_valid === 1'b1) beats_seen++;
      if (addr_valid === 1'b1 && data_valid === 1'b1) overlap_seen = 1;
      if (cmd_valid && !m_ready) stall_seen = 1;
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Called at a negedge; returns at the negedge after the take, valid still high
  task automatic send(input logic [31:0] a, input logic [1:0] c, input logic [127:0] d);
    cmd_valid = 1; cmd_addr = a; cmd_burst = c; cmd_data = d;
    while (!m_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    cmd_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [127:0] d;
    int exp_n;
    rst = 1; cmd_valid = 0; cmd_addr = '0; cmd_burst = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk(addr_valid === 0 && data_valid === 0 && cmd_ready === 1, "R1 in reset",
        {addr_valid, data_valid, cmd_ready}, 3'b001);
    rst = 0;
    @(negedge clk);
    chk(addr_valid === 0 && data_valid === 0 && cmd_ready === 1, "R1 after reset",
        {addr_valid, data_valid, cmd_ready}, 3'b001);
    cmp_on = 1;

    // R6 latency on an idle path, then R3 beat counts for each code
    for (int c = 0; c < 4; c++) begin
      d = rnd128();
      beats_seen = 0;
      send(32'h1000 + c, c[1:0], d);
      chk(addr_valid === 1 && addr_out === 32'h1000 + c, "R2 addr phase one cycle after take",
          addr_out, 32'h1000 + c);
      idle(1);
      chk(data_valid === 1 && data_out === d[31:0], "R6 first beat after address phase",
          data_out, d[31:0]);
      idle(8);
      exp_n = (c == 1) ? 2 : (c == 2) ? 4 : 1;
      chk(beats_seen == exp_n, "R3 beat count", beats_seen, exp_n);
    end

    // Back-to-back quads: overlap, back-pressure, no gap between bursts
    overlap_seen = 0; stall_seen = 0;
    for (int i = 0; i < 8; i++) send(32'h2000 + i, 2'b10, rnd128());
    idle(40);
    chk(overlap_seen, "R10 address overlaps data", overlap_seen, 1);
    chk(stall_seen, "R8 ready dropped under load", stall_seen, 1);

    // Random mix of codes and valid gaps
    for (int i = 0; i < 400; i++) begin
      if (!cmd_valid || m_acc) begin
        cmd_valid = ($urandom % 3) != 0;
        cmd_addr  = $urandom;
        cmd_burst = 2'($urandom);
        cmd_data  = rnd128();
      end
      @(negedge clk);
    end
    idle(30);

    // Reset in the middle of traffic
    for (int i = 0; i < 3; i++) send(32'h3000 + i, 2'b10, rnd128());
    cmp_on = 0;
    rst = 1; cmd_valid = 0;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(addr_valid === 0 && data_valid === 0 && cmd_ready === 1, "R1 reset mid-traffic",
        {addr_valid, data_valid, cmd_ready}, 3'b001);
    cmp_on = 1;
    idle(10);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule